// File: doc/BRIEF.md
# Permission-checked address translation buffer

This block sits beside the load/store path and turns a virtual address into a physical one. It is a small, fully associative buffer. Each entry binds a virtual page number and a process identifier to a physical frame number. Entries belonging to different tasks stay side by side, so a task switch needs no flush. Every entry also carries a read permission, a write permission, a touched flag and a dirty flag. Pages are 4 KB, so the low twelve address bits are passed through as they are.

A lookup returns its result one cycle after it is presented. The result is one of three outcomes:
- a hit, with the translated address;
- a miss fault, which hands the miss to software;
- a protection fault, when the entry matches but the access type is not allowed.

Privileged software fills or invalidates entries through a write port. It reads the suggested replacement slot from a victim output. It also pulses a clear of all touched flags, so that the victim choice approximates least-recently-used. A write or a clear attempted in user mode changes nothing and raises a privilege fault.

Top module: `xlat_buffer`

## Requirements
- R1: While reset is held low at a clock edge, every entry becomes invalid and every registered output goes to zero. After reset, `victim_idx` reads 0.
- R2: A lookup presented with `lk_req` high at a clock edge produces `rsp_valid` = 1 in the following cycle. With no request, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_prot` and `rsp_dirty` are all 0.
- R3: A lookup hits an entry when the entry is valid, its page number equals `lk_va[31:12]` and its process id equals `lk_pid`. On a hit, `rsp_pa` = {frame number, `lk_va[11:0]`}. When several entries match, the lowest index wins.
- R4: A lookup that matches no entry gives `rsp_miss` = 1, `rsp_hit` = 0, `rsp_prot` = 0 and `rsp_pa` = 0.
- R5: `lk_wr` = 1 marks a write and 0 marks a read. A hit whose entry lacks the matching permission gives `rsp_prot` = 1 with `rsp_hit` = 1.
- R6: Any hit sets the touched flag of the matched entry, including a hit that raises a protection fault.
- R7: A permitted write hit sets the entry's dirty flag. `rsp_dirty` reports the dirty flag of the hit entry including the effect of that access, and is 0 on a miss.
- R8: `victim_idx` is the lowest index of an invalid entry. If every entry is valid, it is the lowest index whose touched flag is clear. If every touched flag is set, it is 0.
- R9: `clr_touch` with `cpu_priv` = 1 clears every touched flag. The exception is an entry hit in the same cycle, whose flag is set instead.
- R10: `mw_en` with `cpu_priv` = 1 writes entry `mw_idx`: valid flag, page number, process id, frame, permissions, with touched and dirty cleared. With `cpu_priv` = 0, `mw_en` or `clr_touch` leaves all entries unchanged and sets `priv_fault` = 1 in the next cycle.
- R11: A lookup in the same cycle as an entry write sees the entry contents from before the write.
- R12: The same page number installed under two process ids translates separately for each id, and misses for any other id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_priv | input | 1 | 1 = privileged mode, qualifies the write port and the clear |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Process id of the requester |
| lk_wr | input | 1 | Access type: 1 write, 0 read |
| mw_en | input | 1 | Entry write strobe |
| mw_idx | input | 4 | Entry index to write |
| mw_valid | input | 1 | 1 installs, 0 invalidates |
| mw_vpn | input | 20 | Virtual page number to store |
| mw_pid | input | 8 | Process id to store |
| mw_pfn | input | 12 | Physical frame number to store |
| mw_rd_ok | input | 1 | Read permission to store |
| mw_wr_ok | input | 1 | Write permission to store |
| clr_touch | input | 1 | Pulse clearing all touched flags |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Lookup matched an entry |
| rsp_pa | output | 24 | Physical address |
| rsp_miss | output | 1 | Miss fault |
| rsp_prot | output | 1 | Protection fault |
| rsp_dirty | output | 1 | Dirty flag of the hit entry |
| priv_fault | output | 1 | User-mode write or clear attempted last cycle |
| victim_idx | output | 4 | Suggested replacement entry |

## Verification
The assertions assume that `lk_req` and the write strobes are driven to known values at every clock edge, and that the bench holds `lk_req` low while reset is applied. Under those conditions they hold without conditions on address or id contents, duplicate entries included. Stimulus stays inside this: every input is driven away from the clock edge from defined values. The random phase draws page numbers and process ids from a small pool, so hits, duplicates, faults, user-mode attempts and same-cycle write/lookup collisions all occur often.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the translation buffer: default geometry and the
// access-type encoding. Assumes callers override only via module parameters.
package xlat_pkg;
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_VA_W    = 32;
    localparam int DEF_PA_W    = 24;
    localparam int DEF_OFS_W   = 12;
    localparam int DEF_PID_W   = 8;

    // Access kind carried on the lookup port.
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;
endpackage

// File: rtl/xlat_entry_store.sv
`timescale 1ns/1ps
// Entry storage: holds the tag, frame, permissions and the touched/dirty
// flags of every slot. Assumes at most one slot is written per cycle and
// that the one-hot update vectors come from the priority match.
// An entry write overrides any flag update to the same slot.
module xlat_entry_store #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PFN_W = 12,
    parameter int PID_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_fire,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_valid,
    input  logic [VPN_W-1:0]          wr_vpn,
    input  logic [PID_W-1:0]          wr_pid,
    input  logic [PFN_W-1:0]          wr_pfn,
    input  logic                      wr_rd_ok,
    input  logic                      wr_wr_ok,
    input  logic [N-1:0]              touch_oh,
    input  logic [N-1:0]              dirty_oh,
    input  logic                      clr_fire,
    output logic [N-1:0]              e_valid,
    output logic [N-1:0][VPN_W-1:0]   e_vpn,
    output logic [N-1:0][PID_W-1:0]   e_pid,
    output logic [N-1:0][PFN_W-1:0]   e_pfn,
    output logic [N-1:0]              e_rd_ok,
    output logic [N-1:0]              e_wr_ok,
    output logic [N-1:0]              e_touched,
    output logic [N-1:0]              e_dirty
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic sel;
        assign sel = wr_fire && (wr_idx == IDX_W'(g));

        // Slot contents: load on a privileged write, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[g] <= 1'b0;
                e_vpn[g]   <= '0;
                e_pid[g]   <= '0;
                e_pfn[g]   <= '0;
                e_rd_ok[g] <= 1'b0;
                e_wr_ok[g] <= 1'b0;
            end else if (sel) begin
                e_valid[g] <= wr_valid;
                e_vpn[g]   <= wr_vpn;
                e_pid[g]   <= wr_pid;
                e_pfn[g]   <= wr_pfn;
                e_rd_ok[g] <= wr_rd_ok;
                e_wr_ok[g] <= wr_wr_ok;
            end
        end

        // Usage flags: set by hits, cleared by install or the clear pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_touched[g] <= 1'b0;
                e_dirty[g]   <= 1'b0;
            end else if (sel) begin
                e_touched[g] <= 1'b0;
                e_dirty[g]   <= 1'b0;
            end else begin
                if (touch_oh[g])
                    e_touched[g] <= 1'b1;
                else if (clr_fire)
                    e_touched[g] <= 1'b0;
                if (dirty_oh[g])
                    e_dirty[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
// Associative compare: tests every valid slot against the requested page
// number and process id, then keeps only the lowest-indexed match.
// Purely combinational; assumes the caller registers the result.
module xlat_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             e_valid,
    input  logic [N-1:0][VPN_W-1:0]  e_vpn,
    input  logic [N-1:0][PID_W-1:0]  e_pid,
    input  logic [VPN_W-1:0]         q_vpn,
    input  logic [PID_W-1:0]         q_pid,
    output logic                     m_any,
    output logic [IDX_W-1:0]         m_idx,
    output logic [N-1:0]             m_oh
);
    logic [N-1:0] raw;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign raw[g] = e_valid[g] && (e_vpn[g] == q_vpn) && (e_pid[g] == q_pid);
    end

    // Priority pick: scanning downward leaves the lowest match in place.
    always_comb begin
        m_idx = '0;
        m_oh  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (raw[i]) begin
                m_idx = IDX_W'(i);
                m_oh  = N'(1) << i;
            end
        end
        m_any = |raw;
    end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
// Replacement suggestion: prefers the lowest invalid slot, then the lowest
// slot not touched since the last clear, else slot 0.
// Combinational from the stored flags.
module xlat_victim #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     e_valid,
    input  logic [N-1:0]     e_touched,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] cold_idx;
    logic             free_any;
    logic             cold_any;

    // Two lowest-index searches, one over empty slots, one over cold slots.
    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        free_any = 1'b0;
        cold_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!e_valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
            if (!e_touched[i]) begin
                cold_idx = IDX_W'(i);
                cold_any = 1'b1;
            end
        end
    end

    // Final choice in priority order.
    always_comb begin
        if (free_any)
            victim = free_idx;
        else if (cold_any)
            victim = cold_idx;
        else
            victim = '0;
    end
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
// Translation buffer top: one-cycle lookup with permission check, process-
// tagged entries, touched/dirty tracking and a privileged entry write port.
// Assumes software serves misses and keeps page tables; the lookup samples
// the entries as they were before any same-cycle write.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VA_W    = DEF_VA_W,
    parameter int PA_W    = DEF_PA_W,
    parameter int OFS_W   = DEF_OFS_W,
    parameter int PID_W   = DEF_PID_W,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PFN_W  = PA_W - OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_priv,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_va,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             lk_wr,
    input  logic             mw_en,
    input  logic [IDX_W-1:0] mw_idx,
    input  logic             mw_valid,
    input  logic [VPN_W-1:0] mw_vpn,
    input  logic [PID_W-1:0] mw_pid,
    input  logic [PFN_W-1:0] mw_pfn,
    input  logic             mw_rd_ok,
    input  logic             mw_wr_ok,
    input  logic             clr_touch,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_miss,
    output logic             rsp_prot,
    output logic             rsp_dirty,
    output logic             priv_fault,
    output logic [IDX_W-1:0] victim_idx
);
    logic [ENTRIES-1:0]             e_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
    logic [ENTRIES-1:0][PID_W-1:0]  e_pid;
    logic [ENTRIES-1:0][PFN_W-1:0]  e_pfn;
    logic [ENTRIES-1:0]             e_rd_ok;
    logic [ENTRIES-1:0]             e_wr_ok;
    logic [ENTRIES-1:0]             e_touched;
    logic [ENTRIES-1:0]             e_dirty;

    logic                m_any;
    logic [IDX_W-1:0]    m_idx;
    logic [ENTRIES-1:0]  m_oh;

    acc_e                acc;
    logic                hit_now;
    logic                allow;
    logic                wr_ok_now;
    logic [ENTRIES-1:0]  touch_oh;
    logic [ENTRIES-1:0]  dirty_oh;
    logic                wr_fire;
    logic                clr_fire;

    assign acc      = acc_e'(lk_wr);
    assign wr_fire  = mw_en && cpu_priv;
    assign clr_fire = clr_touch && cpu_priv;

    xlat_match #(
        .N     (ENTRIES),
        .VPN_W (VPN_W),
        .PID_W (PID_W)
    ) u_match (
        .e_valid (e_valid),
        .e_vpn   (e_vpn),
        .e_pid   (e_pid),
        .q_vpn   (lk_va[VA_W-1:OFS_W]),
        .q_pid   (lk_pid),
        .m_any   (m_any),
        .m_idx   (m_idx),
        .m_oh    (m_oh)
    );

    // Permission check of the selected slot against the access kind.
    always_comb begin
        hit_now   = lk_req && m_any;
        allow     = (acc == ACC_WRITE) ? e_wr_ok[m_idx] : e_rd_ok[m_idx];
        wr_ok_now = hit_now && (acc == ACC_WRITE) && allow;
        touch_oh  = hit_now ? m_oh : '0;
        dirty_oh  = wr_ok_now ? m_oh : '0;
    end

    xlat_entry_store #(
        .N     (ENTRIES),
        .VPN_W (VPN_W),
        .PFN_W (PFN_W),
        .PID_W (PID_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .wr_idx    (mw_idx),
        .wr_valid  (mw_valid),
        .wr_vpn    (mw_vpn),
        .wr_pid    (mw_pid),
        .wr_pfn    (mw_pfn),
        .wr_rd_ok  (mw_rd_ok),
        .wr_wr_ok  (mw_wr_ok),
        .touch_oh  (touch_oh),
        .dirty_oh  (dirty_oh),
        .clr_fire  (clr_fire),
        .e_valid   (e_valid),
        .e_vpn     (e_vpn),
        .e_pid     (e_pid),
        .e_pfn     (e_pfn),
        .e_rd_ok   (e_rd_ok),
        .e_wr_ok   (e_wr_ok),
        .e_touched (e_touched),
        .e_dirty   (e_dirty)
    );

    xlat_victim #(
        .N (ENTRIES)
    ) u_victim (
        .e_valid   (e_valid),
        .e_touched (e_touched),
        .victim    (victim_idx)
    );

    // Response register: one cycle from request to result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pa    <= '0;
            rsp_miss  <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= hit_now;
            rsp_pa    <= hit_now ? {e_pfn[m_idx], lk_va[OFS_W-1:0]} : '0;
            rsp_miss  <= lk_req && !m_any;
            rsp_prot  <= hit_now && !allow;
            rsp_dirty <= hit_now && (e_dirty[m_idx] || wr_ok_now);
        end
    end

    // Privilege violation flag for user-mode maintenance attempts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            priv_fault <= 1'b0;
        else
            priv_fault <= (mw_en || clr_touch) && !cpu_priv;
    end
endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
// Property checker for the translation buffer, bound onto every instance.
// Observes ports only; assumes inputs are known at each clock edge.
module xlat_buffer_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 24,
    parameter int OFS_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_priv,
    input logic            lk_req,
    input logic [VA_W-1:0] lk_va,
    input logic            mw_en,
    input logic            clr_touch,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_miss,
    input logic            rsp_prot,
    input logic            rsp_dirty,
    input logic            priv_fault
);
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot || rsp_dirty)); // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_pa[OFS_W-1:0] == $past(lk_va[OFS_W-1:0])); // R3

    AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> !rsp_hit && !rsp_prot && rsp_pa == '0); // R4

    AST_PROT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot |-> rsp_hit); // R5

    AST_USER_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_en && !cpu_priv) |=> priv_fault); // R10

    AST_USER_CLEAR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_touch && !cpu_priv) |=> priv_fault); // R9

    AST_PRIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_priv || !(mw_en || clr_touch)) |=> !priv_fault); // R10
endmodule

bind xlat_buffer xlat_buffer_chk #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_priv   (cpu_priv),
    .lk_req     (lk_req),
    .lk_va      (lk_va),
    .mw_en      (mw_en),
    .clr_touch  (clr_touch),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_pa     (rsp_pa),
    .rsp_miss   (rsp_miss),
    .rsp_prot   (rsp_prot),
    .rsp_dirty  (rsp_dirty),
    .priv_fault (priv_fault)
);

// File: tb/xlat_buffer_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios plus a random phase, with a behavioural model
// compared against every output on every clock.
module xlat_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_priv = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_wr = 1'b0;
    logic        mw_en = 1'b0;
    logic [3:0]  mw_idx = '0;
    logic        mw_valid = 1'b0;
    logic [19:0] mw_vpn = '0;
    logic [7:0]  mw_pid = '0;
    logic [11:0] mw_pfn = '0;
    logic        mw_rd_ok = 1'b0;
    logic        mw_wr_ok = 1'b0;
    logic        clr_touch = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_dirty, priv_fault;
    logic [23:0] rsp_pa;
    logic [3:0]  victim_idx;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit armed = 0;

    always #2.5 clk = ~clk;

    xlat_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_priv(cpu_priv),
        .lk_req(lk_req), .lk_va(lk_va), .lk_pid(lk_pid), .lk_wr(lk_wr),
        .mw_en(mw_en), .mw_idx(mw_idx), .mw_valid(mw_valid), .mw_vpn(mw_vpn),
        .mw_pid(mw_pid), .mw_pfn(mw_pfn), .mw_rd_ok(mw_rd_ok), .mw_wr_ok(mw_wr_ok),
        .clr_touch(clr_touch),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
        .rsp_miss(rsp_miss), .rsp_prot(rsp_prot), .rsp_dirty(rsp_dirty),
        .priv_fault(priv_fault), .victim_idx(victim_idx)
    );

    // Reference state, kept as plain bench arrays.
    bit        mv[16];
    int        mvpn[16], mpid[16], mpfn[16];
    bit        mrd[16], mwr[16], mt[16], md[16];
    bit        x_valid, x_hit, x_miss, x_prot, x_dirty, x_pf;
    int        x_pa;

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        int hi;
        bit ok;
        armed = 1;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                mv[i] = 0; mt[i] = 0; md[i] = 0;
            end
            x_valid = 0; x_hit = 0; x_miss = 0; x_prot = 0; x_dirty = 0;
            x_pf = 0; x_pa = 0;
        end else begin
            hi = -1;
            ok = 0;
            for (int i = 15; i >= 0; i--)
                if (mv[i] && mvpn[i] == int'(lk_va[31:12]) && mpid[i] == int'(lk_pid))
                    hi = i;
            x_pf = (mw_en || clr_touch) && !cpu_priv;
            x_valid = lk_req;
            x_hit = 0; x_miss = 0; x_prot = 0; x_dirty = 0; x_pa = 0;
            if (lk_req && hi < 0) x_miss = 1;
            if (lk_req && hi >= 0) begin
                ok = lk_wr ? mwr[hi] : mrd[hi];
                x_hit = 1;
                x_prot = !ok;
                x_pa = mpfn[hi] * 4096 + int'(lk_va[11:0]);
                x_dirty = md[hi] || (lk_wr && ok);
            end
            if (clr_touch && cpu_priv)
                for (int i = 0; i < 16; i++) mt[i] = 0;
            if (lk_req && hi >= 0) begin
                mt[hi] = 1;
                if (lk_wr && ok) md[hi] = 1;
            end
            if (mw_en && cpu_priv) begin
                mv[mw_idx] = mw_valid; mvpn[mw_idx] = int'(mw_vpn);
                mpid[mw_idx] = int'(mw_pid); mpfn[mw_idx] = int'(mw_pfn);
                mrd[mw_idx] = mw_rd_ok; mwr[mw_idx] = mw_wr_ok;
                mt[mw_idx] = 0; md[mw_idx] = 0;
            end
        end
    end

    function automatic int model_victim();
        for (int i = 0; i < 16; i++) if (!mv[i]) return i;
        for (int i = 0; i < 16; i++) if (!mt[i]) return i;
        return 0;
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model comparison on every falling edge.
    always @(negedge clk) begin
        if (armed) begin
            cmp("R2", "rsp_valid", int'(rsp_valid), int'(x_valid));
            cmp("R3", "rsp_hit", int'(rsp_hit), int'(x_hit));
            cmp("R3", "rsp_pa", int'(rsp_pa), x_pa);
            cmp("R4", "rsp_miss", int'(rsp_miss), int'(x_miss));
            cmp("R5", "rsp_prot", int'(rsp_prot), int'(x_prot));
            cmp("R7", "rsp_dirty", int'(rsp_dirty), int'(x_dirty));
            cmp("R10", "priv_fault", int'(priv_fault), int'(x_pf));
            cmp("R8", "victim_idx", int'(victim_idx), model_victim());
        end
    end

    task automatic install(input int idx, input bit v, input int vpn, input int pid,
                           input int pfn, input bit rd, input bit wr);
        mw_en = 1; mw_idx = 4'(idx); mw_valid = v; mw_vpn = 20'(vpn);
        mw_pid = 8'(pid); mw_pfn = 12'(pfn); mw_rd_ok = rd; mw_wr_ok = wr;
        @(negedge clk);
        mw_en = 0;
    endtask

    task automatic look(input int va, input int pid, input bit wr);
        lk_req = 1; lk_va = 32'(va); lk_pid = 8'(pid); lk_wr = wr;
        @(negedge clk);
        lk_req = 0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: cleared state after reset
        cmp("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        cmp("R1", "victim after reset", int'(victim_idx), 0);

        install(0, 1, 'h12345, 1, 'hABC, 1, 1);
        install(1, 1, 'h00010, 1, 'h055, 1, 0);
        install(2, 1, 'h12345, 2, 'h777, 1, 1);
        install(3, 1, 'h00020, 1, 'h0F0, 0, 1);
        cmp("R8", "victim after four installs", int'(victim_idx), 4);

        look('h12345678, 1, 0);
        cmp("R3", "pa read hit", int'(rsp_pa), 'hABC678);
        look('h12345678, 2, 0);
        cmp("R12", "pa other pid", int'(rsp_pa), 'h777678);
        look('h12345678, 3, 0);
        cmp("R12", "unknown pid misses", int'(rsp_miss), 1);
        cmp("R4", "miss pa zero", int'(rsp_pa), 0);
        look('h00010004, 1, 1);
        cmp("R5", "write to read-only", int'(rsp_prot), 1);
        look('h00020000, 1, 0);
        cmp("R5", "read without read perm", int'(rsp_prot), 1);
        look('h12345010, 1, 1);
        cmp("R7", "dirty on write hit", int'(rsp_dirty), 1);
        look('h12345000, 1, 0);
        cmp("R7", "dirty retained", int'(rsp_dirty), 1);
        look('h12345000, 2, 0);
        cmp("R7", "other entry clean", int'(rsp_dirty), 0);

        cpu_priv = 0;
        install(0, 1, 'h12345, 1, 'h111, 1, 1);
        cmp("R10", "user write faults", int'(priv_fault), 1);
        cpu_priv = 1;
        look('h12345000, 1, 0);
        cmp("R10", "user write ignored", int'(rsp_pa), 'hABC000);

        for (int i = 4; i < 16; i++) install(i, 1, 'h40 + i, 1, i, 1, 1);
        cmp("R8", "victim lowest untouched", int'(victim_idx), 4);
        look('h00044000, 1, 0);
        cmp("R6", "hit marks touched", int'(victim_idx), 5);
        look('h00010000, 1, 1);
        cmp("R6", "faulting hit still touches", int'(victim_idx), 5);

        cpu_priv = 0; clr_touch = 1;
        @(negedge clk);
        clr_touch = 0; cpu_priv = 1;
        cmp("R9", "user clear faults", int'(priv_fault), 1);
        cmp("R9", "user clear ignored", int'(victim_idx), 5);
        clr_touch = 1;
        @(negedge clk);
        clr_touch = 0;
        cmp("R9", "privileged clear", int'(victim_idx), 0);

        // R11: write and lookup of the same slot in one cycle
        mw_en = 1; mw_idx = 0; mw_valid = 1; mw_vpn = 'h12345; mw_pid = 1;
        mw_pfn = 'h222; mw_rd_ok = 1; mw_wr_ok = 1;
        lk_req = 1; lk_va = 'h12345ABC; lk_pid = 1; lk_wr = 0;
        @(negedge clk);
        mw_en = 0; lk_req = 0;
        cmp("R11", "lookup sees old entry", int'(rsp_pa), 'hABCABC);
        look('h12345ABC, 1, 0);
        cmp("R11", "later lookup sees new entry", int'(rsp_pa), 'h222ABC);

        // Random phase against the model.
        for (int n = 0; n < 3000; n++) begin
            int pool[4] = '{'h12345, 'h00010, 'h00044, 'h00001};
            lk_req   = ($urandom % 4) != 0;
            lk_va    = {20'(pool[$urandom % 4]), 12'($urandom)};
            lk_pid   = 8'(1 + $urandom % 2);
            lk_wr    = 1'($urandom);
            mw_en    = ($urandom % 5) == 0;
            mw_idx   = 4'($urandom);
            mw_valid = ($urandom % 4) != 0;
            mw_vpn   = 20'(pool[$urandom % 4]);
            mw_pid   = 8'(1 + $urandom % 2);
            mw_pfn   = 12'($urandom);
            mw_rd_ok = 1'($urandom);
            mw_wr_ok = 1'($urandom);
            clr_touch = ($urandom % 16) == 0;
            cpu_priv = ($urandom % 8) != 0;
            @(negedge clk);
        end
        lk_req = 0; mw_en = 0; clr_touch = 0; cpu_priv = 1;
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule